// File: doc/BRIEF.md
# Interrupt Entry Stack Switcher

This block performs the stack side of interrupt and exception entry in a 64-bit processor core. When the entry sequencer raises `start_i`, the block takes a snapshot of the interrupted context: old SS, old RSP, RFLAGS, CS, RIP and an optional error code. It then decides whether the stack moves, picks the new stack top and writes the return frame onto the new stack as a series of 8-byte stores.

Each gate carries a 3-bit stack-table index. A nonzero index names one of seven alternate stack pointers, and that vector always switches stacks. An index of zero uses the per-privilege pointers. In that case the stack moves only when the target privilege level differs from the current one, and the pointer for the target level is used. On a switch, SS becomes a null selector whose RPL carries the new level. No descriptor is loaded.

The chosen top is aligned down to 16 bytes. The frame is written downwards, one slot per cycle. A one-cycle done pulse then presents the final RSP and the new SS. The pointer file is loaded through a simple write port.

Top module: `int_entry_stack_sw`

## Requirements
- R1: While reset is asserted and after its release, `busy_o`, `wr_valid_o` and `done_o` are 0, and `rsp_o` and `ss_o` are 0.
- R2: A nonzero stack-table index k (1..7) selects alternate pointer k as the base and forces a stack switch, even when `tgt_cpl_i` equals `cpl_i`.
- R3: With index 0 and `tgt_cpl_i` different from `cpl_i`, the base is the per-privilege pointer for `tgt_cpl_i`.
- R4: With index 0 and `tgt_cpl_i` equal to `cpl_i`, the base is `rsp_i` and `ss_o` reports `ss_i` unchanged.
- R5: On a stack switch, the new SS is 16 bits wide. Bits [1:0] hold `tgt_cpl_i` and bits [15:2] are zero.
- R6: The base is aligned down to a 16-byte boundary by clearing its low 4 bits. The result is called top.
- R7: Frame slots are written one per cycle, highest address first, starting the cycle after `start_i` is accepted. The order is:
  - top-8: old SS, zero-extended
  - top-16: old RSP
  - top-24: RFLAGS
  - top-32: CS, zero-extended
  - top-40: RIP
  - top-48: error code
- R8: Old SS and old RSP are written in every frame, including frames without a stack switch.
- R9: With `has_err_i` = 0 the frame has 5 slots and the final RSP is top-40, so RIP sits at +0. With `has_err_i` = 1 it has 6 slots and the final RSP is top-48.
- R10: `done_o` pulses for exactly one cycle, immediately after the last write cycle. `rsp_o` and `ss_o` take their final values in that cycle and hold them until the next frame completes.
- R11: `start_i` is ignored while `busy_o` is 1. A start in the done cycle is accepted.
- R12: Pointer file write port: `sp_waddr_i[3]` = 0 writes privilege pointer `sp_waddr_i[1:0]`. `sp_waddr_i[3]` = 1 writes alternate pointer `sp_waddr_i[2:0]` (1..7). A write takes effect at the clock edge and is not seen by a start sampled at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin entry; accepted when not busy |
| cpl_i | input | 2 | Current privilege level |
| tgt_cpl_i | input | 2 | Target code-segment privilege level |
| ist_idx_i | input | 3 | Stack-table index from the gate |
| has_err_i | input | 1 | Error code is pushed |
| ss_i | input | 16 | Old SS selector |
| rsp_i | input | 64 | Old RSP |
| rflags_i | input | 64 | RFLAGS |
| cs_i | input | 16 | CS selector |
| rip_i | input | 64 | Return RIP |
| err_code_i | input | 64 | Error code |
| sp_we_i | input | 1 | Pointer file write enable |
| sp_waddr_i | input | 4 | Pointer file write address |
| sp_wdata_i | input | 64 | Pointer file write data |
| busy_o | output | 1 | Frame in progress |
| wr_valid_o | output | 1 | Stack write valid |
| wr_addr_o | output | 64 | Stack write byte address |
| wr_data_o | output | 64 | Stack write data |
| done_o | output | 1 | Frame complete pulse |
| rsp_o | output | 64 | Final RSP |
| ss_o | output | 16 | New SS selector |

## Verification
The frame is launched from three base sources:
- an alternate index at equal privilege, which separates an unconditional switch from a privilege-driven one;
- index zero with a privilege change, including two different target levels, which shows the per-level pointer lookup and the null SS with its RPL;
- index zero at equal privilege, which shows `rsp_i` reused as the base while the old SS:RSP is still pushed.

Each source is run with and without an error code, which tells the 5-slot layout from the 6-slot one. Unaligned base values expose whether the 16-byte alignment is applied. A start raised in mid-frame must leave the frame untouched, and a start in the done cycle must give back-to-back frames.

// File: rtl/int_entry_pkg.sv
package int_entry_pkg;
  localparam int unsigned SLOT_BYTES  = 8;
  localparam int unsigned ALIGN_BYTES = 16;

  typedef enum logic [2:0] {
    SLOT_SS    = 3'd0,
    SLOT_RSP   = 3'd1,
    SLOT_FLAGS = 3'd2,
    SLOT_CS    = 3'd3,
    SLOT_RIP   = 3'd4,
    SLOT_ERR   = 3'd5
  } slot_e;

  function automatic logic [2:0] frame_slots(input logic has_err);
    return has_err ? 3'd6 : 3'd5;
  endfunction
endpackage

// File: rtl/ise_sp_file.sv
module ise_sp_file #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned CPL_W = 2,
  parameter int unsigned IST_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IST_W:0]   waddr_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic [CPL_W-1:0] priv_sel_i,
  input  logic [IST_W-1:0] alt_sel_i,
  output logic [XLEN-1:0]  priv_sp_o,
  output logic [XLEN-1:0]  alt_sp_o
);
  localparam int unsigned NUM_PRIV = 2 ** CPL_W;
  localparam int unsigned NUM_ALT  = 2 ** IST_W - 1;

  logic [XLEN-1:0] priv_q [NUM_PRIV];
  logic [XLEN-1:0] alt_q  [NUM_ALT+1];

  assign alt_q[0] = '0;

  for (genvar p = 0; p < NUM_PRIV; p++) begin : g_priv
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) priv_q[p] <= '0;
      else if (we_i && !waddr_i[IST_W] && waddr_i[CPL_W-1:0] == CPL_W'(p))
        priv_q[p] <= wdata_i;
    end
  end

  for (genvar a = 1; a <= NUM_ALT; a++) begin : g_alt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) alt_q[a] <= '0;
      else if (we_i && waddr_i[IST_W] && waddr_i[IST_W-1:0] == IST_W'(a))
        alt_q[a] <= wdata_i;
    end
  end

  assign priv_sp_o = priv_q[priv_sel_i];
  assign alt_sp_o  = alt_q[alt_sel_i];
endmodule

// File: rtl/ise_frame_seq.sv
module ise_frame_seq
  import int_entry_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned SEL_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [XLEN-1:0]  top_i,
  input  logic [2:0]       slots_i,
  input  logic [SEL_W-1:0] old_ss_i,
  input  logic [XLEN-1:0]  old_rsp_i,
  input  logic [XLEN-1:0]  flags_i,
  input  logic [SEL_W-1:0] cs_i,
  input  logic [XLEN-1:0]  rip_i,
  input  logic [XLEN-1:0]  err_i,
  input  logic [XLEN-1:0]  final_rsp_i,
  input  logic [SEL_W-1:0] new_ss_i,
  output logic             busy_o,
  output logic             wr_valid_o,
  output logic [XLEN-1:0]  wr_addr_o,
  output logic [XLEN-1:0]  wr_data_o,
  output logic             done_o,
  output logic [XLEN-1:0]  rsp_o,
  output logic [SEL_W-1:0] ss_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(SLOT_BYTES);

  logic             busy_q, done_q;
  logic [2:0]       idx_q, slots_q;
  logic [XLEN-1:0]  addr_q;
  logic [SEL_W-1:0] oss_q, cs_q, nss_q, ss_q;
  logic [XLEN-1:0]  orsp_q, flags_q, rip_q, err_q, fin_q, rsp_q;
  logic             last;

  assign last = (idx_q == slots_q - 3'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
      slots_q <= '0;
      addr_q  <= '0;
      oss_q   <= '0;
      cs_q    <= '0;
      nss_q   <= '0;
      orsp_q  <= '0;
      flags_q <= '0;
      rip_q   <= '0;
      err_q   <= '0;
      fin_q   <= '0;
      rsp_q   <= '0;
      ss_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        addr_q <= addr_q - STEP;
        idx_q  <= idx_q + 3'd1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          rsp_q  <= fin_q;
          ss_q   <= nss_q;
        end
      end else if (load_i) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        slots_q <= slots_i;
        addr_q  <= top_i - STEP;
        oss_q   <= old_ss_i;
        orsp_q  <= old_rsp_i;
        flags_q <= flags_i;
        cs_q    <= cs_i;
        rip_q   <= rip_i;
        err_q   <= err_i;
        fin_q   <= final_rsp_i;
        nss_q   <= new_ss_i;
      end
    end
  end

  always_comb begin
    unique case (slot_e'(idx_q))
      SLOT_SS:    wr_data_o = {{(XLEN-SEL_W){1'b0}}, oss_q};
      SLOT_RSP:   wr_data_o = orsp_q;
      SLOT_FLAGS: wr_data_o = flags_q;
      SLOT_CS:    wr_data_o = {{(XLEN-SEL_W){1'b0}}, cs_q};
      SLOT_RIP:   wr_data_o = rip_q;
      SLOT_ERR:   wr_data_o = err_q;
      default:    wr_data_o = '0;
    endcase
  end

  assign busy_o     = busy_q;
  assign wr_valid_o = busy_q;
  assign wr_addr_o  = addr_q;
  assign done_o     = done_q;
  assign rsp_o      = rsp_q;
  assign ss_o       = ss_q;
endmodule

// File: rtl/int_entry_stack_sw.sv
module int_entry_stack_sw
  import int_entry_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned SEL_W = 16,
  parameter int unsigned CPL_W = 2,
  parameter int unsigned IST_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CPL_W-1:0] cpl_i,
  input  logic [CPL_W-1:0] tgt_cpl_i,
  input  logic [IST_W-1:0] ist_idx_i,
  input  logic             has_err_i,
  input  logic [SEL_W-1:0] ss_i,
  input  logic [XLEN-1:0]  rsp_i,
  input  logic [XLEN-1:0]  rflags_i,
  input  logic [SEL_W-1:0] cs_i,
  input  logic [XLEN-1:0]  rip_i,
  input  logic [XLEN-1:0]  err_code_i,
  input  logic             sp_we_i,
  input  logic [IST_W:0]   sp_waddr_i,
  input  logic [XLEN-1:0]  sp_wdata_i,
  output logic             busy_o,
  output logic             wr_valid_o,
  output logic [XLEN-1:0]  wr_addr_o,
  output logic [XLEN-1:0]  wr_data_o,
  output logic             done_o,
  output logic [XLEN-1:0]  rsp_o,
  output logic [SEL_W-1:0] ss_o
);
  localparam int unsigned ALIGN_SH = $clog2(ALIGN_BYTES);
  localparam int unsigned SLOT_SH  = $clog2(SLOT_BYTES);
  localparam logic [XLEN-1:0] ALIGN_MASK = ~((XLEN'(1) << ALIGN_SH) - XLEN'(1));

  logic [XLEN-1:0]  priv_sp, alt_sp, base, top, final_rsp;
  logic [SEL_W-1:0] new_ss;
  logic [2:0]       slots;
  logic             use_alt, do_switch, busy;

  ise_sp_file #(.XLEN(XLEN), .CPL_W(CPL_W), .IST_W(IST_W)) u_sp_file (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (sp_we_i),
    .waddr_i   (sp_waddr_i),
    .wdata_i   (sp_wdata_i),
    .priv_sel_i(tgt_cpl_i),
    .alt_sel_i (ist_idx_i),
    .priv_sp_o (priv_sp),
    .alt_sp_o  (alt_sp)
  );

  always_comb begin
    use_alt   = (ist_idx_i != '0);
    do_switch = use_alt || (tgt_cpl_i != cpl_i);
    if (use_alt)        base = alt_sp;
    else if (do_switch) base = priv_sp;
    else                base = rsp_i;
    top       = base & ALIGN_MASK;
    slots     = frame_slots(has_err_i);
    final_rsp = top - ({{(XLEN-3){1'b0}}, slots} << SLOT_SH);
    new_ss    = do_switch ? {{(SEL_W-CPL_W){1'b0}}, tgt_cpl_i} : ss_i;
  end

  ise_frame_seq #(.XLEN(XLEN), .SEL_W(SEL_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_i && !busy),
    .top_i      (top),
    .slots_i    (slots),
    .old_ss_i   (ss_i),
    .old_rsp_i  (rsp_i),
    .flags_i    (rflags_i),
    .cs_i       (cs_i),
    .rip_i      (rip_i),
    .err_i      (err_code_i),
    .final_rsp_i(final_rsp),
    .new_ss_i   (new_ss),
    .busy_o     (busy),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .done_o     (done_o),
    .rsp_o      (rsp_o),
    .ss_o       (ss_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/ise_checker.sv
module ise_checker #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned SEL_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             wr_valid_o,
  input logic [XLEN-1:0]  wr_addr_o,
  input logic             done_o,
  input logic [XLEN-1:0]  rsp_o,
  input logic [SEL_W-1:0] ss_o
);
  logic [2:0] wcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         wcnt_q <= '0;
    else if (done_o)     wcnt_q <= '0;
    else if (wr_valid_o) wcnt_q <= wcnt_q + 3'd1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(wr_valid_o) && !busy_o); // R10
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && $past(wr_valid_o)) |-> wr_addr_o == $past(wr_addr_o) - XLEN'(8)); // R7
  AST_ADDR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> wr_addr_o[2:0] == 3'b000); // R6
  AST_FRAME_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (wcnt_q == 3'd5 || wcnt_q == 3'd6)); // R9
  AST_FINAL_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rsp_o[2:0] == 3'b000); // R9
  AST_RSP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rsp_o) && $stable(ss_o)); // R10
endmodule

bind int_entry_stack_sw ise_checker #(.XLEN(XLEN), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/tb_int_entry_stack_sw.sv
`timescale 1ns/1ps
module tb_int_entry_stack_sw;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cpl = '0, tgt = '0;
  logic [2:0]  ist = '0;
  logic        has_err = 1'b0;
  logic [15:0] ss = '0, cs = '0;
  logic [63:0] rsp = '0, flags = '0, rip = '0, err = '0;
  logic        sp_we = 1'b0;
  logic [3:0]  sp_waddr = '0;
  logic [63:0] sp_wdata = '0;
  logic        busy, wr_valid, done;
  logic [63:0] wr_addr, wr_data, rsp_out;
  logic [15:0] ss_out;

  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  int_entry_stack_sw dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cpl_i(cpl), .tgt_cpl_i(tgt),
    .ist_idx_i(ist), .has_err_i(has_err), .ss_i(ss), .rsp_i(rsp), .rflags_i(flags),
    .cs_i(cs), .rip_i(rip), .err_code_i(err), .sp_we_i(sp_we), .sp_waddr_i(sp_waddr),
    .sp_wdata_i(sp_wdata), .busy_o(busy), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .done_o(done), .rsp_o(rsp_out), .ss_o(ss_out)
  );

  // reference model state
  logic [63:0] m_priv [4];
  logic [63:0] m_alt  [8];
  logic [63:0] qa[$], qd[$];
  logic        m_done = 1'b0;
  logic [63:0] m_rsp = '0, pend_rsp = '0;
  logic [15:0] m_ss = '0, pend_ss = '0;
  int          writes_seen = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic void model_start();
    logic [63:0] base, top;
    bit sw;
    sw = (ist != 0) || (tgt != cpl);
    base = (ist != 0) ? m_alt[ist] : (sw ? m_priv[tgt] : rsp);
    top = {base[63:4], 4'h0};
    qa.push_back(top - 8);  qd.push_back({48'h0, ss});
    qa.push_back(top - 16); qd.push_back(rsp);
    qa.push_back(top - 24); qd.push_back(flags);
    qa.push_back(top - 32); qd.push_back({48'h0, cs});
    qa.push_back(top - 40); qd.push_back(rip);
    if (has_err) begin qa.push_back(top - 48); qd.push_back(err); end
    pend_rsp = top - (has_err ? 64'd48 : 64'd40);
    pend_ss  = sw ? {14'h0, tgt} : ss;
  endfunction

  task automatic tick();
    bit was_idle;
    was_idle = (qa.size() == 0);
    @(posedge clk);
    m_done = 1'b0;
    if (!was_idle) begin
      void'(qa.pop_front());
      void'(qd.pop_front());
      writes_seen++;
      if (qa.size() == 0) begin
        m_done = 1'b1;
        m_rsp = pend_rsp;
        m_ss = pend_ss;
      end
    end else if (start) begin
      model_start();
    end
    if (sp_we) begin
      if (!sp_waddr[3]) m_priv[sp_waddr[1:0]] = sp_wdata;
      else if (sp_waddr[2:0] != 0) m_alt[sp_waddr[2:0]] = sp_wdata;
    end
    @(negedge clk);
    check(busy == (qa.size() != 0), "R11 busy", {63'h0, busy}, {63'h0, qa.size() != 0});
    check(wr_valid == (qa.size() != 0), "R7 wr_valid", {63'h0, wr_valid}, {63'h0, qa.size() != 0});
    if (qa.size() != 0) begin
      check(wr_addr == qa[0], "R7 wr_addr", wr_addr, qa[0]);
      check(wr_data == qd[0], "R7/R8 wr_data", wr_data, qd[0]);
    end
    check(done == m_done, "R10 done", {63'h0, done}, {63'h0, m_done});
    check(rsp_out == m_rsp, "R10 rsp_o", rsp_out, m_rsp);
    check(ss_out == m_ss, "R5 ss_o", {48'h0, ss_out}, {48'h0, m_ss});
  endtask

  task automatic wr_ptr(input logic [3:0] a, input logic [63:0] d);
    sp_we = 1'b1; sp_waddr = a; sp_wdata = d;
    tick();
    sp_we = 1'b0;
  endtask

  task automatic launch(input logic [1:0] c, input logic [1:0] t, input logic [2:0] k,
                        input bit e, input logic [63:0] r, input int busy_starts);
    cpl = c; tgt = t; ist = k; has_err = e; rsp = r;
    ss = 16'h002b + {14'h0, c}; cs = 16'h0033; flags = 64'h0000_0000_0000_0246 ^ r;
    rip = 64'hffff_8000_1234_5670 + {61'h0, k}; err = 64'h0000_0000_0000_00e0 + {62'h0, t};
    start = 1'b1;
    tick();
    start = 1'b0;
    for (int i = 0; i < 20 && !m_done; i++) begin
      if (i < busy_starts) begin
        // R11: stray start with other operands while busy
        start = 1'b1; ist = 3'd1; rsp = 64'h1; cpl = 2'd2;
      end else begin
        start = 1'b0;
      end
      tick();
    end
    start = 1'b0;
    if (!m_done) check(1'b0, "R10 done never seen", 64'h0, 64'h1);
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 64'h0, 64'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] exp;
    for (int i = 0; i < 4; i++) m_priv[i] = '0;
    for (int i = 0; i < 8; i++) m_alt[i] = '0;
    repeat (2) @(negedge clk);
    // R1: reset values
    check(!busy && !wr_valid && !done, "R1 ctrl in reset", {61'h0, busy, wr_valid, done}, 64'h0);
    check(rsp_out == 0 && ss_out == 0, "R1 rsp/ss in reset", rsp_out, 64'h0);
    rst_n = 1'b1;
    tick();
    check(!busy && !done && rsp_out == 0, "R1 after release", {62'h0, busy, done}, 64'h0);

    // R12: load pointer file (unaligned values)
    for (int p = 0; p < 4; p++) wr_ptr(4'(p), 64'h0000_7000_0000_1003 + 64'(p) * 64'h100);
    for (int a = 1; a < 8; a++) wr_ptr(4'(8 + a), 64'h0000_ff00_0000_0009 + 64'(a) * 64'h1000);

    // R2: alt index at equal privilege, with error code
    launch(2'd0, 2'd0, 3'd3, 1'b1, 64'h0000_0000_00ab_cde8, 0);
    exp = 64'h0000_ff00_0000_3000 - 64'd48;
    check(rsp_out == exp, "R2/R6/R9 alt3 final rsp", rsp_out, exp);
    check(ss_out == 16'h0000, "R5 alt3 null ss rpl0", {48'h0, ss_out}, 64'h0);

    // R3: privilege change 3->0, back-to-back
    launch(2'd3, 2'd0, 3'd0, 1'b1, 64'h0000_7fff_ffff_e123, 0);
    exp = 64'h0000_7000_0000_1000 - 64'd48;
    check(rsp_out == exp, "R3 priv0 final rsp", rsp_out, exp);
    check(ss_out == 16'h0000, "R5 ss to cpl0", {48'h0, ss_out}, 64'h0);

    // R3/R5: 3->1, no error
    launch(2'd3, 2'd1, 3'd0, 1'b0, 64'h0000_7fff_ffff_e123, 0);
    exp = 64'h0000_7000_0000_1100 - 64'd40;
    check(rsp_out == exp, "R3/R9 priv1 final rsp", rsp_out, exp);
    check(ss_out == 16'h0001, "R5 ss rpl1", {48'h0, ss_out}, 64'h1);

    // R4/R8: no switch, no error
    repeat (2) tick();
    launch(2'd0, 2'd0, 3'd0, 1'b0, 64'h0000_0000_0010_0fff, 0);
    exp = 64'h0000_0000_0010_0ff0 - 64'd40;
    check(rsp_out == exp, "R4/R9 same-cpl final rsp", rsp_out, exp);
    check(ss_out == 16'h002b, "R4 ss kept", {48'h0, ss_out}, 64'h2b);
    check(writes_seen > 0, "R8 frame written", 64'(writes_seen), 64'h1);

    // R2: alt7 with privilege change, no error
    launch(2'd3, 2'd0, 3'd7, 1'b0, 64'h0000_0000_0000_5555, 0);
    exp = 64'h0000_ff00_0000_7000 - 64'd40;
    check(rsp_out == exp, "R2 alt7 final rsp", rsp_out, exp);

    // R11: stray starts during the frame
    writes_seen = 0;
    launch(2'd2, 2'd0, 3'd5, 1'b1, 64'h0000_0000_0000_7777, 3);
    exp = 64'h0000_ff00_0000_5000 - 64'd48;
    check(rsp_out == exp, "R11 frame unchanged by busy start", rsp_out, exp);
    check(writes_seen == 6, "R11 write count", 64'(writes_seen), 64'd6);

    // R10: outputs held while idle
    repeat (3) tick();
    check(rsp_out == exp && !done, "R10 hold while idle", rsp_out, exp);

    // R12: pointer rewrite then use
    wr_ptr(4'd2, 64'h0000_0000_0abc_0018);
    launch(2'd3, 2'd2, 3'd0, 1'b1, 64'h0000_0000_0000_1000, 0);
    exp = 64'h0000_0000_0abc_0010 - 64'd48;
    check(rsp_out == exp, "R12 rewritten priv2", rsp_out, exp);
    check(ss_out == 16'h0002, "R5 ss rpl2", {48'h0, ss_out}, 64'h2);

    repeat (2) tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule